// File: doc/BRIEF.md
# Shared-Bus Register Datapath with Microsequenced Swap and Double

This block has two working registers, A and B, and an accumulator-style register C. The three are joined by one shared bus and a two-function ALU. The ALU's first operand is always C and its second operand is the bus. It can pass the bus value through, or add C and the bus with the sum wrapping at the data width. C captures the ALU result on every clock edge. A and B capture C only when the controller enables their load.

A small sequencer takes a one-bit opcode together with a start strobe. It then steps through a fixed three-cycle schedule of bus, ALU and load controls:

- Opcode 0 exchanges A and B.
- Opcode 1 replaces A with twice its value.

While the sequencer is idle, a host can preload A and B through dedicated write ports. All three registers are visible on debug outputs.

Top module: `bdp_core`

## Requirements
- R1: During and immediately after synchronous reset, `busy` and `done` are 0 and A, B and C all read zero.
- R2: While idle, a pulse on `init_a_we` or `init_b_we` writes the matching value into A or B at the next edge. No bus source is driven, so C reads 0 in every idle cycle that follows an idle cycle. B holds its value across any idle cycle without `init_b_we`.
- R3: With opcode 0 (exchange), the values of A and B are swapped when `done` is high.
- R4: With opcode 1 (double), A equals 2·A modulo 2^WIDTH when `done` is high, and B is unchanged.
- R5: An accepted start makes `busy` high for exactly three consecutive cycles, beginning in the cycle after the start edge.
- R6: `done` is high for exactly one cycle: the first cycle after the last busy cycle. The results are already visible on `dbg_a` and `dbg_b` in that cycle.
- R7: A `start` pulse while `busy` is high is ignored. No further busy cycles follow the current instruction.
- R8: The A bus driver and the B bus driver are never enabled in the same cycle.
- R9: `init_a_we` and `init_b_we` are ignored while `busy` is high, so they do not alter the instruction's result.
- R10: In the second busy cycle of either opcode, C holds the value that A had at the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start strobe, sampled only while idle |
| op | input | 1 | Opcode: 0 exchange A/B, 1 double A |
| init_a_we | input | 1 | Preload enable for A (idle only) |
| init_a_val | input | WIDTH | Preload value for A |
| init_b_we | input | 1 | Preload enable for B (idle only) |
| init_b_val | input | WIDTH | Preload value for B |
| busy | output | 1 | High while the three-step schedule runs |
| done | output | 1 | One-cycle completion pulse |
| dbg_a | output | WIDTH | Current contents of A |
| dbg_b | output | WIDTH | Current contents of B |
| dbg_c | output | WIDTH | Current contents of C |

## Verification
The bench builds the block with WIDTH = 8. At that width, doubling an operand of 128 or more visibly drops the carry, so the wraparound of R4 can be observed directly on `dbg_a`. Eight bits also give room for distinct, recognisable A and B patterns, so a swapped or unchanged register cannot be confused with its partner. The same width keeps the junk values written during busy cycles clearly different from every expected result.

// File: rtl/bdp_pkg.sv
package bdp_pkg;

    typedef enum logic {
        OP_SWAP = 1'b0,
        OP_TWOX = 1'b1
    } opcode_e;

    typedef enum logic {
        ALU_PASS = 1'b0,
        ALU_ADD  = 1'b1
    } alu_fn_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_STEP1 = 2'd1,
        ST_STEP2 = 2'd2,
        ST_STEP3 = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic    drv_a;
        logic    drv_b;
        alu_fn_e alu_fn;
        logic    ld_a;
        logic    ld_b;
    } ctrl_t;

    localparam ctrl_t CTRL_QUIET = '{
        drv_a: 1'b0, drv_b: 1'b0, alu_fn: ALU_PASS, ld_a: 1'b0, ld_b: 1'b0
    };

    // Control word for one step of the schedule.
    function automatic ctrl_t step_ctrl(seq_state_e st, opcode_e op);
        ctrl_t c;
        c = CTRL_QUIET;
        case (st)
            ST_STEP1: begin
                c.drv_a = 1'b1;            // C <= A
            end
            ST_STEP2: begin
                if (op == OP_SWAP) begin
                    c.drv_b = 1'b1;        // C <= B, B <= old C
                    c.ld_b  = 1'b1;
                end else begin
                    c.drv_a  = 1'b1;       // C <= C + A
                    c.alu_fn = ALU_ADD;
                end
            end
            ST_STEP3: begin
                c.ld_a = 1'b1;             // A <= C, bus idle
            end
            default: c = CTRL_QUIET;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/bdp_alu.sv
module bdp_alu
    import bdp_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] x_in,
    input  logic [WIDTH-1:0] y_in,
    input  alu_fn_e          fn,
    output logic [WIDTH-1:0] result
);
    always_comb begin
        case (fn)
            ALU_ADD: result = x_in + y_in;   // carry discarded
            default: result = y_in;
        endcase
    end
endmodule

// File: rtl/bdp_seq.sv
module bdp_seq
    import bdp_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  opcode_e op,
    output ctrl_t   ctrl,
    output logic    busy,
    output logic    done
);
    seq_state_e state_q, state_d;
    opcode_e    op_q;
    logic       done_q;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:  if (start) state_d = ST_STEP1;
            ST_STEP1: state_d = ST_STEP2;
            ST_STEP2: state_d = ST_STEP3;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            op_q    <= OP_SWAP;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == ST_STEP3);
            if (state_q == ST_IDLE && start) begin
                op_q <= op;
            end
        end
    end

    assign ctrl = step_ctrl(state_q, op_q);
    assign busy = (state_q != ST_IDLE);
    assign done = done_q;
endmodule

// File: rtl/bdp_datapath.sv
module bdp_datapath
    import bdp_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  ctrl_t            ctrl,
    input  logic             idle,
    input  logic             init_a_we,
    input  logic [WIDTH-1:0] init_a_val,
    input  logic             init_b_we,
    input  logic [WIDTH-1:0] init_b_val,
    output logic [WIDTH-1:0] reg_a,
    output logic [WIDTH-1:0] reg_b,
    output logic [WIDTH-1:0] reg_c
);
    logic [WIDTH-1:0] bus;
    logic [WIDTH-1:0] alu_out;

    // Bus source select in place of tri-state drivers; undriven reads zero.
    always_comb begin
        case ({ctrl.drv_a, ctrl.drv_b})
            2'b10:   bus = reg_a;
            2'b01:   bus = reg_b;
            default: bus = '0;
        endcase
    end

    bdp_alu #(.WIDTH(WIDTH)) u_alu (
        .x_in   (reg_c),
        .y_in   (bus),
        .fn     (ctrl.alu_fn),
        .result (alu_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_a <= '0;
            reg_b <= '0;
            reg_c <= '0;
        end else begin
            reg_c <= alu_out;
            if (ctrl.ld_a)                reg_a <= reg_c;
            else if (idle && init_a_we)   reg_a <= init_a_val;
            if (ctrl.ld_b)                reg_b <= reg_c;
            else if (idle && init_b_we)   reg_b <= init_b_val;
        end
    end
endmodule

// File: rtl/bdp_core.sv
module bdp_core
    import bdp_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             op,
    input  logic             init_a_we,
    input  logic [WIDTH-1:0] init_a_val,
    input  logic             init_b_we,
    input  logic [WIDTH-1:0] init_b_val,
    output logic             busy,
    output logic             done,
    output logic [WIDTH-1:0] dbg_a,
    output logic [WIDTH-1:0] dbg_b,
    output logic [WIDTH-1:0] dbg_c
);
    ctrl_t ctrl_w;
    logic  busy_w;

    bdp_seq u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .op    (opcode_e'(op)),
        .ctrl  (ctrl_w),
        .busy  (busy_w),
        .done  (done)
    );

    bdp_datapath #(.WIDTH(WIDTH)) u_dp (
        .clk        (clk),
        .rst        (rst),
        .ctrl       (ctrl_w),
        .idle       (!busy_w),
        .init_a_we  (init_a_we),
        .init_a_val (init_a_val),
        .init_b_we  (init_b_we),
        .init_b_val (init_b_val),
        .reg_a      (dbg_a),
        .reg_b      (dbg_b),
        .reg_c      (dbg_c)
    );

    assign busy = busy_w;
endmodule

// File: rtl/bdp_core_chk.sv
module bdp_core_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             done,
    input logic             init_b_we,
    input logic [WIDTH-1:0] dbg_b,
    input logic [WIDTH-1:0] dbg_c,
    input logic             drv_a,
    input logic             drv_b
);
    AST_BUS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(drv_a && drv_b)) else $error("bus contention"); // R8

    AST_BUSY_THREE: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(busy, 1) && $past(busy, 2) && $past(busy, 3) && !$past(busy, 4)))
        else $error("busy length"); // R5

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done) else $error("done width"); // R6

    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy) else $error("done while busy"); // R6

    AST_IDLE_C_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!busy && $past(!busy)) |-> (dbg_c == '0)) else $error("C not zero idle"); // R2

    AST_B_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!busy && !init_b_we) |=> $stable(dbg_b)) else $error("B moved"); // R2
endmodule

bind bdp_core bdp_core_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .done      (done),
    .init_b_we (init_b_we),
    .dbg_b     (dbg_b),
    .dbg_c     (dbg_c),
    .drv_a     (ctrl_w.drv_a),
    .drv_b     (ctrl_w.drv_b)
);

// File: tb/bdp_core_bench.sv
module bdp_core_bench;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         op = 1'b0;
    logic         init_a_we = 1'b0;
    logic [W-1:0] init_a_val = '0;
    logic         init_b_we = 1'b0;
    logic [W-1:0] init_b_val = '0;
    logic         busy, done;
    logic [W-1:0] dbg_a, dbg_b, dbg_c;

    always #4 clk = ~clk;   // 125 MHz

    bdp_core #(.WIDTH(W)) u_bdp_core (
        .clk(clk), .rst(rst), .start(start), .op(op),
        .init_a_we(init_a_we), .init_a_val(init_a_val),
        .init_b_we(init_b_we), .init_b_val(init_b_val),
        .busy(busy), .done(done), .dbg_a(dbg_a), .dbg_b(dbg_b), .dbg_c(dbg_c)
    );

    typedef struct {
        string        tag;
        logic [W-1:0] a;
        logic [W-1:0] b;
    } exp_t;

    exp_t         exp_q[$];
    int           checks = 0;
    int           failures = 0;
    logic [W-1:0] ref_a = '0;
    logic [W-1:0] ref_b = '0;
    bit           ended = 0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic report();
        if (!ended) begin
            ended = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Monitor: pop expected results when the design signals completion.
    always @(negedge clk) begin
        if (!rst && done) begin
            if (exp_q.size() == 0) begin
                chk("R6 unexpected done", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk({e.tag, " A"}, 32'(dbg_a), 32'(e.a));
                chk({e.tag, " B"}, 32'(dbg_b), 32'(e.b));
            end
        end
    end

    task automatic preload(logic [W-1:0] a, logic [W-1:0] b);
        @(negedge clk);
        init_a_we = 1; init_a_val = a; init_b_we = 1; init_b_val = b;
        @(negedge clk);
        init_a_we = 0; init_b_we = 0;
        ref_a = a; ref_b = b;
        chk("R2 preload A", 32'(dbg_a), 32'(a));
        chk("R2 preload B", 32'(dbg_b), 32'(b));
        @(negedge clk);
        chk("R2 C zero idle", 32'(dbg_c), 32'd0);
    endtask

    // Driver: push the expected result, then run one instruction.
    task automatic run_instr(logic opv, bit poke);
        exp_t         e;
        int           nb;
        logic [W-1:0] old_a;
        old_a = ref_a;
        e.tag = opv ? "R4 double" : "R3 swap";
        e.a   = opv ? W'(ref_a << 1) : ref_b;
        e.b   = opv ? ref_b : ref_a;
        if (poke) e.tag = {e.tag, " R9"};
        exp_q.push_back(e);
        ref_a = e.a; ref_b = e.b;
        op = opv; start = 1;
        @(negedge clk);
        start = 0;
        nb = 0;
        while (busy && nb < 10) begin
            nb++;
            if (nb == 2) chk("R10 C holds old A", 32'(dbg_c), 32'(old_a));
            if (poke && nb >= 2) begin
                start = 1;
                init_a_we = 1; init_a_val = 8'hEE;
                init_b_we = 1; init_b_val = 8'hDD;
            end
            @(negedge clk);
            start = 0; init_a_we = 0; init_b_we = 0;
        end
        chk("R5 busy cycles", 32'(nb), 32'd3);
        chk("R6 done after busy", 32'(done), 32'd1);
        @(negedge clk);
        chk("R6 done one cycle", 32'(done), 32'd0);
        if (poke) chk("R7 no restart", 32'(busy), 32'd0);
        chk("R6 A holds", 32'(dbg_a), 32'(e.a));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 busy", 32'(busy), 32'd0);
        chk("R1 done", 32'(done), 32'd0);
        chk("R1 A", 32'(dbg_a), 32'd0);
        chk("R1 B", 32'(dbg_b), 32'd0);
        chk("R1 C", 32'(dbg_c), 32'd0);
        rst = 0;
        @(negedge clk);
        chk("R1 after release", 32'(dbg_a | dbg_b | dbg_c), 32'd0);

        preload(8'h12, 8'h34);
        run_instr(1'b0, 1'b0);      // R3 swap -> 34/12
        run_instr(1'b1, 1'b0);      // R4 double 34 -> 68
        preload(8'hC8, 8'h5A);
        run_instr(1'b1, 1'b0);      // R4 wrap C8 -> 90
        run_instr(1'b0, 1'b1);      // R3 swap with R7/R9 pokes
        run_instr(1'b1, 1'b1);      // R4 double with pokes
        preload(8'h80, 8'h01);
        run_instr(1'b1, 1'b0);      // R4 80 -> 00
        run_instr(1'b0, 1'b0);      // R3 back swap
        repeat (2) @(negedge clk);
        chk("R2 C zero after runs", 32'(dbg_c), 32'd0);
        chk("R3 R4 queue drained", 32'(exp_q.size()), 32'd0);
        report();
    end
endmodule